// File: doc/BRIEF.md
# Framed Serial Control and Readout Port

This block is the serial-mode host port of a multi-channel converter. A host supplies a serial clock plus two active-low frame syncs. While the transmit sync is low, the host shifts a six-bit control word into the port on a data-in line. While the receive sync is low, the port shifts out a sixteen-bit word on a data-out line. That word holds a four-bit header (format bit and channel address) followed by the 12-bit conversion result. The result is coded as straight binary or as two's complement, as the format bit selects.

A write frame updates the control register only once its sixth bit has arrived. A frame that closes early leaves the register untouched. If such a short frame ends while the software-start bit is already set, the port raises a one-cycle conversion request for the engine next to it.

All serial inputs are sampled by a faster system clock. A serial-clock falling edge is seen as high in one system cycle and low in the next. Both frames may run on one shared sync line at the same time.

Top module: `sframePort`

## Requirements
- R1: While `tfsN` is low, `dataIn` is captured on each of the first six detected falling edges of `sclk`. The first bit lands in `ctrlAddr[2]`, then `ctrlAddr[1]`, `ctrlAddr[0]`, `ctrlSwStart`, `ctrlStandby`, and last `ctrlFormat`. Further edges in the same frame have no effect on the register.
- R2: The control outputs take the new six-bit value in the system cycle after the sixth captured edge. They never change while `tfsN` is high.
- R3: If `tfsN` returns high after fewer than six captured edges, the control outputs keep their previous value.
- R4: When such a short frame closes while `ctrlSwStart` is 1, `convReq` is high for exactly one cycle, in the cycle after `tfsN` is first seen high. When `ctrlSwStart` is 0, or the frame was complete, `convReq` stays low.
- R5: On the cycle after `rfsN` is first seen low, the port freezes a word of the form {format, A2, A1, A0, result[11:0]}. It drives bit 15 first on `dataOut` and moves to the next lower bit after each detected falling edge of `sclk`.
- R6: With format 1 the frozen result has its MSB inverted (two's complement of an offset-binary value). With format 0 it is passed unchanged.
- R7: `dataOut` is 0 whenever `rfsN` was high at the previous clock, and after the sixteenth falling edge of a read frame.
- R8: After reset all control outputs, `convReq` and `dataOut` are 0.
- R9: With one shared sync, a read and a write run in the same frame. The read header and coding use the control value from before that frame's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock, synchronous to `clk` |
| tfsN | input | 1 | Active-low write frame sync |
| rfsN | input | 1 | Active-low read frame sync |
| dataIn | input | 1 | Serial control data from host |
| result | input | 12 | Latest conversion result, straight binary |
| dataOut | output | 1 | Serial readout data |
| ctrlAddr | output | 3 | Channel address field |
| ctrlSwStart | output | 1 | Software-start bit |
| ctrlStandby | output | 1 | Software-standby bit |
| ctrlFormat | output | 1 | Output coding select, 1 = two's complement |
| convReq | output | 1 | One-cycle conversion request from a short frame |

## Verification
Two operations can fall in the same cycle. In full-duplex operation, the sixth write edge can commit a new format and address while a readout of the same frame is still shifting its header. The bench provokes this by tying both syncs low together and writing a control word that changes both the format and the address. It judges the result by checking that the header and result coding read back match the value held before the frame. Aborted short frames are also run with the software-start bit both clear and set, and the request pulse is checked against a behavioural model on every clock.

// File: rtl/sframePkg.sv
package sframePkg;
  localparam int CTRL_W = 6;
  localparam int ADDR_W = 3;
  localparam int RES_W  = 12;
  localparam int WORD_W = 1 + ADDR_W + RES_W;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int WCNT_W = $clog2(CTRL_W + 1);

  typedef struct packed {
    logic             shiftEn;
    logic             commit;
    logic             loadWord;
    logic             drive;
    logic [IDX_W-1:0] bitIdx;
  } strobe_t;
endpackage

// File: rtl/sframeCtrl.sv
module sframeCtrl
  import sframePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    tfsN,
  input  logic    rfsN,
  input  logic    swStart,
  output strobe_t strb,
  output logic    convReq
);
  localparam logic [WCNT_W-1:0] WR_LAST = WCNT_W'(CTRL_W - 1);
  localparam logic [WCNT_W-1:0] WR_FULL = WCNT_W'(CTRL_W);
  localparam logic [IDX_W-1:0]  RD_TOP  = IDX_W'(WORD_W - 1);

  logic sclkQ, tfsQ, rfsQ;
  logic fallEdge;
  logic [WCNT_W-1:0] wrCnt;
  logic [IDX_W-1:0]  rdIdx;
  logic rdDone;
  logic wrOpen;

  assign fallEdge = sclkQ & ~sclk;
  assign wrOpen   = wrCnt < WR_FULL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      tfsQ  <= 1'b1;
      rfsQ  <= 1'b1;
    end else begin
      sclkQ <= sclk;
      tfsQ  <= tfsN;
      rfsQ  <= rfsN;
    end
  end

  // write frame bit counter, saturating at the register width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt   <= '0;
      convReq <= 1'b0;
    end else begin
      convReq <= tfsN & ~tfsQ & wrOpen & swStart;
      if (tfsN)
        wrCnt <= '0;
      else if (fallEdge && wrOpen)
        wrCnt <= wrCnt + 1'b1;
    end
  end

  // read frame bit index, counting down from the word MSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx  <= RD_TOP;
      rdDone <= 1'b1;
    end else if (strb.loadWord) begin
      rdIdx  <= RD_TOP;
      rdDone <= 1'b0;
    end else if (!rfsN && fallEdge && !rdDone) begin
      if (rdIdx == '0)
        rdDone <= 1'b1;
      else
        rdIdx <= rdIdx - 1'b1;
    end
  end

  always_comb begin
    strb.shiftEn  = ~tfsN & fallEdge & wrOpen;
    strb.commit   = strb.shiftEn & (wrCnt == WR_LAST);
    strb.loadWord = ~rfsN & rfsQ;
    strb.drive    = ~rfsQ & ~rdDone;
    strb.bitIdx   = rdIdx;
  end
endmodule

// File: rtl/sframeData.sv
module sframeData
  import sframePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataIn,
  input  logic [RES_W-1:0]  result,
  input  strobe_t           strb,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              dataOut
);
  logic [CTRL_W-2:0] shiftReg;
  logic [WORD_W-1:0] outWord;
  logic [RES_W-1:0]  coded;
  logic              fmtBit;

  assign fmtBit = ctrlReg[0];
  assign coded  = {result[RES_W-1] ^ fmtBit, result[RES_W-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ctrlReg  <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[CTRL_W-3:0], dataIn};
      if (strb.commit)
        ctrlReg <= {shiftReg, dataIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      outWord <= '0;
    else if (strb.loadWord)
      outWord <= {fmtBit, ctrlReg[CTRL_W-1 -: ADDR_W], coded};
  end

  assign dataOut = strb.drive & outWord[strb.bitIdx];
endmodule

// File: rtl/sframePort.sv
module sframePort
  import sframePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              tfsN,
  input  logic              rfsN,
  input  logic              dataIn,
  input  logic [RES_W-1:0]  result,
  output logic              dataOut,
  output logic [ADDR_W-1:0] ctrlAddr,
  output logic              ctrlSwStart,
  output logic              ctrlStandby,
  output logic              ctrlFormat,
  output logic              convReq
);
  strobe_t           strb;
  logic [CTRL_W-1:0] ctrlReg;

  sframeCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .tfsN(tfsN), .rfsN(rfsN),
    .swStart(ctrlReg[2]), .strb(strb), .convReq(convReq)
  );

  sframeData u_data (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .result(result),
    .strb(strb), .ctrlReg(ctrlReg), .dataOut(dataOut)
  );

  assign ctrlAddr    = ctrlReg[CTRL_W-1 -: ADDR_W];
  assign ctrlSwStart = ctrlReg[2];
  assign ctrlStandby = ctrlReg[1];
  assign ctrlFormat  = ctrlReg[0];
endmodule

// File: rtl/sframeChk.sv
module sframeChk (
  input logic       clk,
  input logic       rstN,
  input logic       sclk,
  input logic       tfsN,
  input logic       rfsN,
  input logic       dataOut,
  input logic [2:0] ctrlAddr,
  input logic       ctrlSwStart,
  input logic       ctrlStandby,
  input logic       ctrlFormat,
  input logic       convReq
);
  logic [5:0] ctrlAll;
  assign ctrlAll = {ctrlAddr, ctrlSwStart, ctrlStandby, ctrlFormat};

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    convReq |=> !convReq);

  p_req_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> ($past(tfsN) && !$past(tfsN, 2) && ctrlSwStart));

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(tfsN) |-> $stable(ctrlAll));

  p_ctrl_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlAll) |-> (!$past(sclk) && $past(sclk, 2)));

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rfsN) |-> !dataOut);
endmodule

bind sframePort sframeChk u_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .tfsN(tfsN), .rfsN(rfsN),
  .dataOut(dataOut), .ctrlAddr(ctrlAddr), .ctrlSwStart(ctrlSwStart),
  .ctrlStandby(ctrlStandby), .ctrlFormat(ctrlFormat), .convReq(convReq)
);

// File: tb/sim_sframePort.sv
`timescale 1ns/1ps
module sim_sframePort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, tfsN = 1'b1, rfsN = 1'b1, dataIn = 1'b0;
  logic [11:0] result = 12'h000;
  logic dataOut, ctrlSwStart, ctrlStandby, ctrlFormat, convReq;
  logic [2:0] ctrlAddr;

  int total = 0, bad = 0, reqSeen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sframePort u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .tfsN(tfsN), .rfsN(rfsN),
    .dataIn(dataIn), .result(result), .dataOut(dataOut), .ctrlAddr(ctrlAddr),
    .ctrlSwStart(ctrlSwStart), .ctrlStandby(ctrlStandby),
    .ctrlFormat(ctrlFormat), .convReq(convReq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  bit mSclkP, mTfsP, mRfsP, mReq, fall;
  int mCnt, mRd;
  bit [5:0] mSh, mCtrl;
  bit [15:0] mWord;

  always @(posedge clk) begin
    if (!rstN) begin
      mSclkP = 0; mTfsP = 1; mRfsP = 1; mReq = 0;
      mCnt = 0; mRd = 16; mSh = 0; mCtrl = 0; mWord = 0;
    end else begin
      fall = mSclkP && !sclk;
      if (!rfsN && mRfsP) begin
        mWord = {mCtrl[0], mCtrl[5:3], result ^ (mCtrl[0] ? 12'h800 : 12'h000)};
        mRd = 0;
      end else if (!rfsN && fall && mRd < 16) mRd++;
      mReq = 0;
      if (tfsN) begin
        if (!mTfsP && mCnt < 6 && mCtrl[2]) mReq = 1;
        mCnt = 0;
      end else if (fall && mCnt < 6) begin
        mSh = {mSh[4:0], dataIn};
        mCnt++;
        if (mCnt == 6) mCtrl = mSh;
      end
      mSclkP = sclk; mTfsP = tfsN; mRfsP = rfsN;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 ctrl model", {26'd0, ctrlAddr, ctrlSwStart, ctrlStandby, ctrlFormat}, {26'd0, mCtrl});
      chk("R4 convReq model", {31'd0, convReq}, {31'd0, mReq});
      chk("R5 dataOut model", {31'd0, dataOut},
          {31'd0, (!mRfsP && mRd < 16) ? mWord[15 - mRd] : 1'b0});
      if (convReq) reqSeen++;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk) sclk = 1'b1;
    waitN(2);
    sclk = 1'b0;
    waitN(2);
  endtask

  task automatic writeBits(input logic [7:0] bits, input int n);
    @(negedge clk) tfsN = 1'b0;
    waitN(2);
    for (int i = 0; i < n; i++) begin
      dataIn = bits[n - 1 - i];
      pulse();
    end
    tfsN = 1'b1;
    dataIn = 1'b0;
    waitN(3);
  endtask

  // shared = 1 runs a six-bit write on the same frame
  task automatic readWord(input bit shared, input logic [5:0] wbits, output logic [15:0] got);
    @(negedge clk) begin
      rfsN = 1'b0;
      if (shared) tfsN = 1'b0;
    end
    waitN(2);
    for (int i = 0; i < 16; i++) begin
      dataIn = (shared && i < 6) ? wbits[5 - i] : 1'b0;
      got[15 - i] = dataOut;
      pulse();
    end
    chk("R7 dataOut after 16 edges", {31'd0, dataOut}, 32'd0);
    pulse();
    chk("R7 dataOut extra edge", {31'd0, dataOut}, 32'd0);
    rfsN = 1'b1;
    tfsN = 1'b1;
    dataIn = 1'b0;
    waitN(3);
    chk("R7 dataOut idle", {31'd0, dataOut}, 32'd0);
  endtask

  function automatic logic [31:0] ctrlNow();
    return {26'd0, ctrlAddr, ctrlSwStart, ctrlStandby, ctrlFormat};
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    waitN(4);
    chk("R8 reset ctrl", ctrlNow(), 32'd0);
    chk("R8 reset dataOut", {31'd0, dataOut}, 32'd0);
    chk("R8 reset convReq", {31'd0, convReq}, 32'd0);
    @(negedge clk) rstN = 1'b1;
    waitN(3);

    writeBits(8'b00101001, 6);
    chk("R1 six-bit write", ctrlNow(), 32'h29);

    result = 12'h123;
    readWord(0, 6'd0, w);
    chk("R5 R6 read fmt1", {16'd0, w}, 32'hD923);

    writeBits(8'b01001011, 8);
    chk("R1 extra bits ignored", ctrlNow(), 32'h12);

    result = 12'hABC;
    readWord(0, 6'd0, w);
    chk("R6 read fmt0", {16'd0, w}, 32'h2ABC);

    reqSeen = 0;
    writeBits(8'b00000111, 3);
    chk("R3 short frame keeps ctrl", ctrlNow(), 32'h12);
    chk("R4 no request swStart 0", reqSeen, 0);

    writeBits(8'b00011100, 6);
    chk("R2 swStart written", ctrlNow(), 32'h1C);
    chk("R4 no request full frame", reqSeen, 0);

    writeBits(8'b00000000, 2);
    chk("R3 short frame keeps ctrl sw", ctrlNow(), 32'h1C);
    chk("R4 one request short frame", reqSeen, 1);

    reqSeen = 0;
    result = 12'h800;
    readWord(1, 6'b110001, w);
    chk("R9 duplex header old ctrl", {16'd0, w}, 32'h3800);
    chk("R9 duplex write committed", ctrlNow(), 32'h31);
    chk("R4 no request duplex", reqSeen, 0);

    readWord(0, 6'd0, w);
    chk("R6 fmt1 msb flip", {16'd0, w}, 32'hE000);

    waitN(5);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule